// File: doc/BRIEF.md
# Flash command interface with status register

This block is the command front end of an embedded flash macro. A host writes 8-bit command bytes over a simple strobe bus and reads back either array data or an 8-bit status byte. The block sequences the two-byte write and erase commands and lets the host suspend and resume an erase. It samples the programming-voltage indication when an operation is confirmed. Errors are recorded in sticky flags that only an explicit clear command or the reset pin removes.

The cell array and the analog circuits sit outside the block. Array read data arrives on an input and is passed through when the block is in array mode. A behavioural model of the internal program/erase algorithm runs each operation as a series of fixed-length attempts. Each attempt ends by sampling a verify-result input. When the attempt budget is used up, the matching error flag is set.

Top module: `flash_cui`

## Requirements
- R1: The status byte is {ready, erase suspended, erase error, write error, voltage error, 3'b000}: bit 7 is 1 when ready and 0 when busy, bit 6 is the suspend flag, bit 5 is the erase error, bit 4 is the write error, bit 3 is the voltage error, and bits 2..0 are always 0.
- R2: A read is active while chip_sel and out_en are both 1. With no active read, rd_data is 0x00. In array mode rd_data equals arr_rdata; in status mode it shows the status byte. Command 0x70 selects status mode, 0xFF selects array mode, and reset leaves the block in array mode.
- R3: Byte 0x40 followed by any data byte starts a write when vpp_ok is 1 at the data byte. ready_o is 0 from the data byte's clock edge on, and status mode is selected. Each attempt lasts ATTEMPT_CYC cycles and samples verify_pass at its last edge. ready_o returns to 1 at the edge where verify passes.
- R4: If verify_pass is 0 at the end of all WRITE_TRIES write attempts (default 4), ready returns to 1 and the write error bit is set at that same edge.
- R5: Byte 0x20 followed by 0xD0 starts an erase with up to ERASE_TRIES attempts (default 8); when these run out, the erase error bit is set. A byte other than 0xD0 after 0x20 sets both the erase and write error bits and starts nothing.
- R6: When idle, any byte other than 0x70, 0xFF, 0x50, 0x40 and 0x20 sets both the erase and write error bits and selects status mode.
- R7: The erase, write and voltage error bits stay set until command 0x50 or reset. Command 0x50 leaves the read mode unchanged.
- R8: Byte 0xB0 during an erase suspends it from that edge on. Status then reads ready=1 and suspended=1, and no attempt time elapses. While suspended, 0xFF, 0x70 and 0x50 work as usual. Byte 0xD0 resumes the erase: it clears the suspend flag, selects status mode and continues the remaining attempt time.
- R9: While a write or erase is running and not suspended, every command except an erase suspend during an erase is ignored.
- R10: vpp_ok is sampled only at the edge of the write data byte or the erase 0xD0. If it is 0 there, the voltage error bit is set and no operation starts. While the voltage error bit is set, 0x40 and 0x20 are ignored and the next byte is decoded as a fresh command.
- R11: Once a status-mode read has seen a clock edge, rd_data keeps the value it showed when the read began. It holds that value even if the internal status changes, until chip_sel or out_en is 0 at a clock edge.
- R12: Reset (synchronous, active high) aborts any operation, selects array mode and leaves the status byte at 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset pin |
| cmd_wr | input | 1 | Command byte strobe, one byte per cycle |
| cmd_data | input | 8 | Command or write-data byte |
| chip_sel | input | 1 | Chip select, active high |
| out_en | input | 1 | Output enable, active high |
| arr_rdata | input | 8 | Data from the cell array |
| vpp_ok | input | 1 | Programming voltage within range |
| verify_pass | input | 1 | Result of the current attempt's verify |
| rd_data | output | 8 | Read data: array, status or 0x00 |
| ready_o | output | 1 | Live ready bit (status bit 7) |

## Verification
Command effects and algorithm events are registered, so mode changes, error flags, suspend and resume all show at the clock edge that samples the command byte. The write or erase start shows at the edge of its data or confirm byte. Completion comes exactly ATTEMPT_CYC edges per attempt used, not counting suspended cycles, after that start edge. rd_data follows chip_sel, out_en and arr_rdata within the same cycle, while the frozen status value depends on the first edge of an active read. The bench's reference model advances at each rising edge and the outputs are compared two nanoseconds later, once both the model and the design have settled. Inputs change only on falling edges, and directed reads are sampled one nanosecond after the enables rise.

// File: rtl/flash_cui_pkg.sv
package flash_cui_pkg;

    localparam int BYTE_W = 8;

    localparam logic [BYTE_W-1:0] OPC_READ_ARRAY  = 8'hFF;
    localparam logic [BYTE_W-1:0] OPC_READ_STATUS = 8'h70;
    localparam logic [BYTE_W-1:0] OPC_CLEAR       = 8'h50;
    localparam logic [BYTE_W-1:0] OPC_WRITE_SETUP = 8'h40;
    localparam logic [BYTE_W-1:0] OPC_ERASE_SETUP = 8'h20;
    localparam logic [BYTE_W-1:0] OPC_CONFIRM     = 8'hD0;
    localparam logic [BYTE_W-1:0] OPC_SUSPEND     = 8'hB0;

    localparam logic [BYTE_W-1:0] STATUS_AT_RESET = 8'h80;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WRITE_ARMED,
        SEQ_ERASE_ARMED
    } seq_state_e;

    typedef enum logic {
        JOB_WRITE,
        JOB_ERASE
    } job_kind_e;

    typedef struct packed {
        logic ready;
        logic suspended;
        logic erase_err;
        logic write_err;
        logic volt_err;
    } stat_fields_t;

    typedef struct packed {
        logic      start;
        job_kind_e kind;
        logic      suspend;
        logic      resume;
        logic      volt_fail;
        logic      seq_fail;
        logic      clear;
        logic      to_status;
        logic      to_array;
    } cmd_act_t;

    function automatic logic [BYTE_W-1:0] pack_status(stat_fields_t s);
        return {s.ready, s.suspended, s.erase_err, s.write_err, s.volt_err, 3'b000};
    endfunction

endpackage

// File: rtl/flash_cui_decode.sv
module flash_cui_decode
    import flash_cui_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] cmd_data,
    input  logic              vpp_ok,
    input  logic              job_busy,
    input  logic              job_susp,
    input  job_kind_e         job_kind,
    input  logic              volt_err,
    output cmd_act_t          act,
    output logic              status_mode
);

    seq_state_e seq_q, seq_d;
    logic       mode_q;

    always_comb begin
        act   = '0;
        seq_d = seq_q;
        if (cmd_wr) begin
            if (job_busy && !job_susp) begin
                // running: only an erase suspend gets through
                if (cmd_data == OPC_SUSPEND && job_kind == JOB_ERASE) begin
                    act.suspend = 1'b1;
                end
            end else if (job_busy) begin
                // erase parked in suspend
                case (cmd_data)
                    OPC_CONFIRM: begin
                        act.resume    = 1'b1;
                        act.to_status = 1'b1;
                    end
                    OPC_READ_STATUS: act.to_status = 1'b1;
                    OPC_READ_ARRAY:  act.to_array  = 1'b1;
                    OPC_CLEAR:       act.clear     = 1'b1;
                    OPC_SUSPEND: begin
                    end
                    default: begin
                        act.seq_fail  = 1'b1;
                        act.to_status = 1'b1;
                    end
                endcase
            end else begin
                case (seq_q)
                    SEQ_WRITE_ARMED: begin
                        seq_d         = SEQ_IDLE;
                        act.to_status = 1'b1;
                        act.kind      = JOB_WRITE;
                        if (vpp_ok) act.start     = 1'b1;
                        else        act.volt_fail = 1'b1;
                    end
                    SEQ_ERASE_ARMED: begin
                        seq_d         = SEQ_IDLE;
                        act.to_status = 1'b1;
                        act.kind      = JOB_ERASE;
                        if (cmd_data != OPC_CONFIRM) act.seq_fail  = 1'b1;
                        else if (vpp_ok)             act.start     = 1'b1;
                        else                         act.volt_fail = 1'b1;
                    end
                    default: begin
                        case (cmd_data)
                            OPC_READ_STATUS: act.to_status = 1'b1;
                            OPC_READ_ARRAY:  act.to_array  = 1'b1;
                            OPC_CLEAR:       act.clear     = 1'b1;
                            OPC_WRITE_SETUP: begin
                                if (!volt_err) begin
                                    seq_d         = SEQ_WRITE_ARMED;
                                    act.to_status = 1'b1;
                                end
                            end
                            OPC_ERASE_SETUP: begin
                                if (!volt_err) begin
                                    seq_d         = SEQ_ERASE_ARMED;
                                    act.to_status = 1'b1;
                                end
                            end
                            default: begin
                                act.seq_fail  = 1'b1;
                                act.to_status = 1'b1;
                            end
                        endcase
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q  <= SEQ_IDLE;
            mode_q <= 1'b0;
        end else begin
            seq_q <= seq_d;
            if (act.to_array)       mode_q <= 1'b0;
            else if (act.to_status) mode_q <= 1'b1;
        end
    end

    assign status_mode = mode_q;

endmodule

// File: rtl/flash_cui_algo.sv
module flash_cui_algo
    import flash_cui_pkg::*;
#(
    parameter int ATTEMPT_CYC = 4,
    parameter int WRITE_TRIES = 4,
    parameter int ERASE_TRIES = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  job_kind_e start_kind,
    input  logic      suspend,
    input  logic      resume,
    input  logic      verify_pass,
    output logic      busy,
    output logic      susp,
    output job_kind_e kind,
    output logic      fail_write,
    output logic      fail_erase
);

    localparam int MAX_TRIES = (WRITE_TRIES > ERASE_TRIES) ? WRITE_TRIES : ERASE_TRIES;
    localparam int CYC_W     = (ATTEMPT_CYC > 1) ? $clog2(ATTEMPT_CYC) : 1;
    localparam int TRY_W     = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
    localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(ATTEMPT_CYC - 1);
    localparam logic [TRY_W-1:0] W_LAST   = TRY_W'(WRITE_TRIES - 1);
    localparam logic [TRY_W-1:0] E_LAST   = TRY_W'(ERASE_TRIES - 1);

    logic             busy_q, susp_q;
    job_kind_e        kind_q;
    logic [CYC_W-1:0] cyc_q;
    logic [TRY_W-1:0] try_q;
    logic             advance, attempt_end, last_try, give_up;

    assign advance     = busy_q && !susp_q && !suspend;
    assign attempt_end = advance && (cyc_q == CYC_LAST);
    assign last_try    = (kind_q == JOB_ERASE) ? (try_q == E_LAST) : (try_q == W_LAST);
    assign give_up     = attempt_end && !verify_pass && last_try;
    assign fail_write  = give_up && (kind_q == JOB_WRITE);
    assign fail_erase  = give_up && (kind_q == JOB_ERASE);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            susp_q <= 1'b0;
            kind_q <= JOB_WRITE;
            cyc_q  <= '0;
            try_q  <= '0;
        end else begin
            if (start && !busy_q) begin
                busy_q <= 1'b1;
                kind_q <= start_kind;
                cyc_q  <= '0;
                try_q  <= '0;
            end else if (advance) begin
                if (attempt_end) begin
                    cyc_q <= '0;
                    if (verify_pass || last_try) busy_q <= 1'b0;
                    else                         try_q  <= try_q + 1'b1;
                end else begin
                    cyc_q <= cyc_q + 1'b1;
                end
            end
            if (suspend && busy_q && kind_q == JOB_ERASE) susp_q <= 1'b1;
            else if (resume)                              susp_q <= 1'b0;
        end
    end

    assign busy = busy_q;
    assign susp = susp_q;
    assign kind = kind_q;

endmodule

// File: rtl/flash_cui_status.sv
module flash_cui_status
    import flash_cui_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  cmd_act_t          act,
    input  logic              busy,
    input  logic              susp,
    input  logic              fail_write,
    input  logic              fail_erase,
    input  logic              rd_en,
    input  logic              status_mode,
    input  logic [BYTE_W-1:0] arr_rdata,
    output logic [BYTE_W-1:0] rd_data,
    output logic              ready,
    output logic              volt_err
);

    logic              es_q, ws_q, vs_q, held_q;
    logic [BYTE_W-1:0] snap_q, live_b, shown;
    stat_fields_t      live;

    always_comb begin
        live.ready     = !busy || susp;
        live.suspended = susp;
        live.erase_err = es_q;
        live.write_err = ws_q;
        live.volt_err  = vs_q;
        live_b         = pack_status(live);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            es_q   <= 1'b0;
            ws_q   <= 1'b0;
            vs_q   <= 1'b0;
            held_q <= 1'b0;
            snap_q <= STATUS_AT_RESET;
        end else begin
            if (act.clear) begin
                es_q <= 1'b0;
                ws_q <= 1'b0;
                vs_q <= 1'b0;
            end else begin
                if (act.seq_fail || fail_erase) es_q <= 1'b1;
                if (act.seq_fail || fail_write) ws_q <= 1'b1;
                if (act.volt_fail)              vs_q <= 1'b1;
            end
            // capture what the host sees until a read has held across an edge
            if (!held_q) snap_q <= live_b;
            held_q <= rd_en;
        end
    end

    assign shown    = held_q ? snap_q : live_b;
    assign rd_data  = !rd_en ? '0 : (status_mode ? shown : arr_rdata);
    assign ready    = live.ready;
    assign volt_err = vs_q;

endmodule

// File: rtl/flash_cui.sv
module flash_cui
    import flash_cui_pkg::*;
#(
    parameter int ATTEMPT_CYC = 4,
    parameter int WRITE_TRIES = 4,
    parameter int ERASE_TRIES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [7:0] cmd_data,
    input  logic       chip_sel,
    input  logic       out_en,
    input  logic [7:0] arr_rdata,
    input  logic       vpp_ok,
    input  logic       verify_pass,
    output logic [7:0] rd_data,
    output logic       ready_o
);

    cmd_act_t  act;
    logic      status_mode, job_busy, job_susp, fail_w, fail_e, volt_err, rd_en;
    job_kind_e job_kind;

    assign rd_en = chip_sel && out_en;

    flash_cui_decode u_decode (
        .clk         (clk),
        .rst         (rst),
        .cmd_wr      (cmd_wr),
        .cmd_data    (cmd_data),
        .vpp_ok      (vpp_ok),
        .job_busy    (job_busy),
        .job_susp    (job_susp),
        .job_kind    (job_kind),
        .volt_err    (volt_err),
        .act         (act),
        .status_mode (status_mode)
    );

    flash_cui_algo #(
        .ATTEMPT_CYC (ATTEMPT_CYC),
        .WRITE_TRIES (WRITE_TRIES),
        .ERASE_TRIES (ERASE_TRIES)
    ) u_algo (
        .clk         (clk),
        .rst         (rst),
        .start       (act.start),
        .start_kind  (act.kind),
        .suspend     (act.suspend),
        .resume      (act.resume),
        .verify_pass (verify_pass),
        .busy        (job_busy),
        .susp        (job_susp),
        .kind        (job_kind),
        .fail_write  (fail_w),
        .fail_erase  (fail_e)
    );

    flash_cui_status u_status (
        .clk         (clk),
        .rst         (rst),
        .act         (act),
        .busy        (job_busy),
        .susp        (job_susp),
        .fail_write  (fail_w),
        .fail_erase  (fail_e),
        .rd_en       (rd_en),
        .status_mode (status_mode),
        .arr_rdata   (arr_rdata),
        .rd_data     (rd_data),
        .ready       (ready_o),
        .volt_err    (volt_err)
    );

endmodule

// File: rtl/flash_cui_chk.sv
module flash_cui_chk
    import flash_cui_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_wr,
    input logic [7:0] cmd_data,
    input logic       rd_en,
    input logic [7:0] rd_data,
    input logic       status_mode,
    input logic       vpp_ok,
    input logic       job_busy,
    input logic       job_susp,
    input job_kind_e  job_kind,
    input logic       volt_err
);

    assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (rd_en && status_mode) |-> (rd_data[2:0] == 3'b000));

    assert_susp_erase_only_R8: assert property (@(posedge clk) disable iff (rst)
        job_susp |-> (job_busy && job_kind == JOB_ERASE));

    assert_vpp_gate_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(job_busy) |-> $past(vpp_ok));

    assert_volt_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        ($fell(volt_err) && !$past(rst)) |-> $past(cmd_wr && cmd_data == OPC_CLEAR));

    assert_freeze_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en) && $past(rd_en, 2) && status_mode && $past(status_mode))
        |-> $stable(rd_data));

endmodule

bind flash_cui flash_cui_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr      (cmd_wr),
    .cmd_data    (cmd_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .status_mode (status_mode),
    .vpp_ok      (vpp_ok),
    .job_busy    (job_busy),
    .job_susp    (job_susp),
    .job_kind    (job_kind),
    .volt_err    (volt_err)
);

// File: tb/flash_cui_test.sv
module flash_cui_test;

    localparam int ACYC = 4;
    localparam int WTRY = 4;
    localparam int ETRY = 8;

    logic       clk = 1'b0, rst = 1'b1, cmd_wr = 1'b0, chip_sel = 1'b0, out_en = 1'b0;
    logic       vpp_ok = 1'b1, verify_pass = 1'b1;
    logic [7:0] cmd_data = 8'h00, arr_rdata = 8'h3C;
    logic [7:0] rd_data;
    logic       ready_o;
    int         checks = 0, errors = 0;

    always #4 clk = ~clk;

    flash_cui #(.ATTEMPT_CYC(ACYC), .WRITE_TRIES(WTRY), .ERASE_TRIES(ETRY)) uut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
        .chip_sel(chip_sel), .out_en(out_en), .arr_rdata(arr_rdata),
        .vpp_ok(vpp_ok), .verify_pass(verify_pass),
        .rd_data(rd_data), .ready_o(ready_o)
    );

    // behavioural reference model
    bit         m_stat, m_busy, m_erase, m_susp, m_es, m_ws, m_vs, m_held;
    int         m_seq, m_cyc, m_try;
    logic [7:0] m_snap = 8'h80;

    function automatic logic [7:0] m_word();
        return {(!m_busy || m_susp), m_susp, m_es, m_ws, m_vs, 3'b000};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit go, go_erase, do_susp, do_res, do_clr, bad, vfail;
        go = 0; go_erase = 0; do_susp = 0; do_res = 0; do_clr = 0; bad = 0; vfail = 0;
        if (rst) begin
            m_stat = 0; m_busy = 0; m_erase = 0; m_susp = 0;
            m_es = 0; m_ws = 0; m_vs = 0; m_held = 0;
            m_seq = 0; m_cyc = 0; m_try = 0; m_snap = 8'h80;
        end else begin
            if (!m_held) m_snap = m_word();
            m_held = chip_sel && out_en;
            if (cmd_wr) begin
                if (m_busy && !m_susp) begin
                    do_susp = (cmd_data == 8'hB0) && m_erase;
                end else if (m_busy) begin
                    if (cmd_data == 8'hD0) begin do_res = 1; m_stat = 1; end
                    else if (cmd_data == 8'h70) m_stat = 1;
                    else if (cmd_data == 8'hFF) m_stat = 0;
                    else if (cmd_data == 8'h50) do_clr = 1;
                    else if (cmd_data != 8'hB0) begin bad = 1; m_stat = 1; end
                end else if (m_seq == 1) begin
                    m_seq = 0; m_stat = 1;
                    if (vpp_ok) go = 1; else vfail = 1;
                end else if (m_seq == 2) begin
                    m_seq = 0; m_stat = 1;
                    if (cmd_data != 8'hD0) bad = 1;
                    else if (vpp_ok) begin go = 1; go_erase = 1; end
                    else vfail = 1;
                end else begin
                    case (cmd_data)
                        8'h70: m_stat = 1;
                        8'hFF: m_stat = 0;
                        8'h50: do_clr = 1;
                        8'h40: if (!m_vs) begin m_seq = 1; m_stat = 1; end
                        8'h20: if (!m_vs) begin m_seq = 2; m_stat = 1; end
                        default: begin bad = 1; m_stat = 1; end
                    endcase
                end
            end
            if (m_busy && !m_susp && !do_susp) begin
                if (m_cyc == ACYC - 1) begin
                    m_cyc = 0;
                    if (verify_pass) m_busy = 0;
                    else if (m_try == (m_erase ? ETRY : WTRY) - 1) begin
                        m_busy = 0;
                        if (m_erase) m_es = 1; else m_ws = 1;
                    end else m_try++;
                end else m_cyc++;
            end
            if (go) begin m_busy = 1; m_erase = go_erase; m_cyc = 0; m_try = 0; m_susp = 0; end
            if (do_susp) m_susp = 1;
            if (do_res) m_susp = 0;
            if (do_clr) begin m_es = 0; m_ws = 0; m_vs = 0; end
            if (bad) begin m_es = 1; m_ws = 1; end
            if (vfail) m_vs = 1;
        end
    end

    // per-cycle comparison against the model
    always @(posedge clk) begin
        logic [7:0] exp;
        #2;
        if (!rst) begin
            exp = !(chip_sel && out_en) ? 8'h00 :
                  (m_stat ? (m_held ? m_snap : m_word()) : arr_rdata);
            check("R2/R11 rd_data vs model", rd_data, exp);
            check("R3 ready_o vs model", {7'b0, ready_o}, {7'b0, (!m_busy || m_susp)});
        end
    end

    task automatic cmd(logic [7:0] v);
        @(negedge clk);
        cmd_wr = 1'b1; cmd_data = v;
        @(negedge clk);
        cmd_wr = 1'b0;
    endtask

    task automatic peek(string tag, logic [7:0] exp);
        @(negedge clk);
        chip_sel = 1'b1; out_en = 1'b1;
        #1 check(tag, rd_data, exp);
        @(negedge clk);
        chip_sel = 1'b0; out_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R12 / R2: reset state is array mode, ready
        peek("R12 array mode after reset", 8'h3C);
        check("R12 ready after reset", {7'b0, ready_o}, 8'h01);
        cmd(8'h70);
        peek("R1 idle status byte", 8'h80);

        // R3: write passing on first attempt
        verify_pass = 1'b1;
        cmd(8'h40); cmd(8'hAA);
        check("R3 busy after data byte", {7'b0, ready_o}, 8'h00);
        peek("R3 busy status", 8'h00);
        repeat (6) @(negedge clk);
        peek("R3 done status", 8'h80);

        // R4 / R9: write exhausting its attempts, commands ignored while busy
        verify_pass = 1'b0;
        cmd(8'h40); cmd(8'h11); cmd(8'hFF);
        peek("R9 read-array ignored while busy", 8'h00);
        repeat (20) @(negedge clk);
        peek("R4 write error", 8'h90);
        cmd(8'h70);
        peek("R7 error stays set", 8'h90);
        cmd(8'h50);
        peek("R7 clear status", 8'h80);

        // R5: erase exhaustion and broken confirm
        cmd(8'h20); cmd(8'hD0);
        repeat (40) @(negedge clk);
        peek("R5 erase error", 8'hA0);
        cmd(8'h50);
        cmd(8'h20); cmd(8'h55);
        peek("R5 bad confirm", 8'hB0);
        cmd(8'h50);

        // R6: unknown code
        cmd(8'h12);
        peek("R6 unknown code", 8'hB0);
        cmd(8'h50);
        peek("R6 cleared", 8'h80);
        cmd(8'hFF);
        peek("R2 array after 0xFF", 8'h3C);

        // R8: suspend and resume of an erase
        cmd(8'h20); cmd(8'hD0);
        repeat (5) @(negedge clk);
        cmd(8'hB0);
        peek("R8 suspended status", 8'hC0);
        repeat (10) @(negedge clk);
        peek("R8 still suspended", 8'hC0);
        cmd(8'hFF);
        arr_rdata = 8'h5A;
        peek("R8 array read in suspend", 8'h5A);
        cmd(8'hD0);
        peek("R8 resumed busy", 8'h00);
        repeat (40) @(negedge clk);
        peek("R8 resumed erase finishes", 8'hA0);
        cmd(8'h50);

        // R10: voltage sampled at data byte, lockout of setup commands
        vpp_ok = 1'b0;
        cmd(8'h40); cmd(8'h33);
        peek("R10 voltage error", 8'h88);
        vpp_ok = 1'b1;
        cmd(8'h40); cmd(8'hFF);
        arr_rdata = 8'h77;
        peek("R10 setup refused", 8'h77);
        cmd(8'h70);
        peek("R10 error kept", 8'h88);
        cmd(8'h50);

        // R11: status frozen during a held read
        verify_pass = 1'b0;
        cmd(8'h40); cmd(8'h44);
        @(negedge clk);
        chip_sel = 1'b1; out_en = 1'b1;
        #1 check("R11 read starts busy", rd_data, 8'h00);
        repeat (25) @(negedge clk);
        #1 check("R11 frozen value", rd_data, 8'h00);
        check("R11 ready live", {7'b0, ready_o}, 8'h01);
        @(negedge clk); chip_sel = 1'b0;
        @(negedge clk); chip_sel = 1'b1;
        #1 check("R11 refreshed after toggle", rd_data, 8'h90);
        @(negedge clk); chip_sel = 1'b0; out_en = 1'b0;
        cmd(8'h50);

        // R12: reset aborts a running erase
        cmd(8'h20); cmd(8'hD0);
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R12 ready after abort", {7'b0, ready_o}, 8'h01);
        peek("R12 array after abort", 8'h77);
        cmd(8'h70);
        peek("R12 status after abort", 8'h80);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule